// File: doc/BRIEF.md
# Single-Precision Compare Condition Flag Unit

This unit orders two packed single-precision words, a left operand and a right operand, and produces a four-bit condition code together with an invalid-operation indication. The ordering works on the raw words themselves. Sign and magnitude are compared as integers, and the fields are never unpacked. Because of this, infinities, normal numbers and subnormal numbers all order correctly without any normalisation step. Positive and negative zero are treated as equal.

Two control inputs shape each request. The trap-on-quiet control selects the signalling compare. In that mode any NaN operand raises invalid. Without it, only a signalling NaN raises invalid. The zero-right control replaces the right operand with positive zero, which gives the compare-with-zero forms. A request is presented with a one-cycle strobe. The result is registered and appears, marked valid, on the following cycle. It then stays in place until the next request.

Top module: `fcmp_flags`

## Requirements
- R1: While reset is asserted and after it is released, until the first request, `res_valid`, `flags_nzcv` and `invalid_op` are all zero.
- R2: A request accepted on a clock edge with `req_valid` high shows its result on the outputs after that edge, with `res_valid` high for exactly that cycle. Without a request, `res_valid` is low and `flags_nzcv` and `invalid_op` keep their values.
- R3: `flags_nzcv` packs N, Z, C and V in bits 3, 2, 1 and 0. Equal operands give 4'b0110. Operands are equal when the words are identical or when both are zeros of either sign.
- R4: When the signs (bit 31) differ and the operands are not equal, the negative operand is the smaller one. Left smaller gives 4'b1000 and left larger gives 4'b0010.
- R5: When both signs are clear, the larger unsigned word is the larger value. This covers positive infinity (0x7F800000) and subnormals.
- R6: When both signs are set, the order is inverted: the larger unsigned word is the smaller value.
- R7: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are not zero. If either operand is a NaN, the result is 4'b0011, with N and Z clear.
- R8: A NaN with bit 22 clear is signalling and raises `invalid_op` in both compare modes.
- R9: A quiet NaN (bit 22 set) raises `invalid_op` only when `trap_qnan` is high.
- R10: With `zero_rhs` high, the right operand is taken as 0x00000000, and the value on `rhs_word` has no effect on the result.
- R11: `invalid_op` is never set when neither effective operand is a NaN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Compare request strobe |
| lhs_word | input | 32 | Left operand, packed single precision |
| rhs_word | input | 32 | Right operand, packed single precision |
| trap_qnan | input | 1 | Signalling compare: quiet NaNs also raise invalid |
| zero_rhs | input | 1 | Compare against +0 instead of `rhs_word` |
| res_valid | output | 1 | Result valid, one cycle after a request |
| flags_nzcv | output | 4 | Condition code {N,Z,C,V} |
| invalid_op | output | 1 | Invalid-operation indication |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Mixed-sign zeros.** A design that relied on word equality alone would report +0 and -0 as ordered rather than equal.
- **Two negative operands.** A design that forgot the inversion would order them backwards.
- **Infinity against the largest finite value.** This shows whether the all-ones exponent is mistaken for a NaN.
- **NaN cases.** Quiet and signalling NaNs are placed on each side of the compare and run in both compare modes. A wrong quiet-bit test or mode gate shows up as a missing or spurious invalid, and a leaking ordered path shows up as N or Z set next to the unordered code.
- **Compare with zero.** The zero-right form is driven with a NaN on the ignored input, so a design that still looked at that input would report unordered.

A pseudo-random stream mixes zeros, infinities, NaNs and ordinary words back to back. Timing is checked at the same time: the result must appear on the cycle after each request and must hold while the unit is idle.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Condition codes, bit order {N,Z,C,V}
  typedef enum logic [3:0] {
    CMP_NONE = 4'b0000,
    CMP_GT   = 4'b0010,
    CMP_UN   = 4'b0011,
    CMP_EQ   = 4'b0110,
    CMP_LT   = 4'b1000
  } cmp_code_e;

  localparam int OPERAND_CNT = 2;

endpackage

// File: rtl/fcmp_classify.sv
// NaN detection on one operand body (exponent and fraction, sign excluded).
module fcmp_classify #(
  parameter int WORD_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic [WORD_W-2:0] body,
  output logic              is_nan,
  output logic              is_quiet
);
  localparam int FRAC_W = WORD_W - 1 - EXP_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    exp_f    = body[WORD_W-2 -: EXP_W];
    frac_f   = body[FRAC_W-1:0];
    is_nan   = (&exp_f) && (|frac_f);
    is_quiet = frac_f[FRAC_W-1];
  end
endmodule

// File: rtl/fcmp_order.sv
// Ordered comparison of two raw sign-magnitude words.
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] lhs,
  input  logic [WORD_W-1:0] rhs,
  output cmp_code_e         code
);
  localparam int MAG_W = WORD_W - 1;

  logic             sgn_l, sgn_r;
  logic [MAG_W-1:0] mag_or;
  logic             both_zero, same_word, l_below;

  always_comb begin
    sgn_l     = lhs[WORD_W-1];
    sgn_r     = rhs[WORD_W-1];
    mag_or    = lhs[MAG_W-1:0] | rhs[MAG_W-1:0];
    both_zero = ~|mag_or;
    same_word = (lhs == rhs);
    l_below   = (lhs < rhs);
  end

  always_comb begin
    if (same_word || both_zero) begin
      code = CMP_EQ;
    end else if (sgn_l ^ sgn_r) begin
      code = sgn_l ? CMP_LT : CMP_GT;
    end else if (sgn_l ^ l_below) begin
      code = CMP_LT;
    end else begin
      code = CMP_GT;
    end
  end
endmodule

// File: rtl/fcmp_flags.sv
// Registered single-precision compare producing NZCV and invalid.
module fcmp_flags
  import fcmp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [WORD_W-1:0] lhs_word,
  input  logic [WORD_W-1:0] rhs_word,
  input  logic              trap_qnan,
  input  logic              zero_rhs,
  output logic              res_valid,
  output logic [3:0]        flags_nzcv,
  output logic              invalid_op
);
  localparam int MAG_W = WORD_W - 1;

  logic [WORD_W-1:0]      ops [OPERAND_CNT];
  logic [OPERAND_CNT-1:0] nan_v, quiet_v;
  logic                   any_nan, trap_raise;
  cmp_code_e              ord_code;
  logic [3:0]             code_nxt;

  logic [3:0] flags_d, flags_q;
  logic       inv_d, inv_q;
  logic       vld_q;

  always_comb begin
    ops[0] = lhs_word;
    ops[1] = zero_rhs ? '0 : rhs_word;
  end

  for (genvar g = 0; g < OPERAND_CNT; g++) begin : g_cls
    fcmp_classify #(.WORD_W(WORD_W), .EXP_W(EXP_W)) u_cls (
      .body     (ops[g][WORD_W-2:0]),
      .is_nan   (nan_v[g]),
      .is_quiet (quiet_v[g])
    );
  end

  fcmp_order #(.WORD_W(WORD_W)) u_ord (
    .lhs  (ops[0]),
    .rhs  (ops[1]),
    .code (ord_code)
  );

  // Next-state
  always_comb begin
    any_nan    = |nan_v;
    trap_raise = |(nan_v & (~quiet_v | {OPERAND_CNT{trap_qnan}}));
    code_nxt   = any_nan ? CMP_UN : ord_code;
    flags_d    = flags_q;
    inv_d      = inv_q;
    if (req_valid) begin
      flags_d = code_nxt;
      inv_d   = trap_raise;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= 4'b0000;
      inv_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      inv_q   <= inv_d;
      vld_q   <= req_valid;
    end
  end

  assign res_valid  = vld_q;
  assign flags_nzcv = flags_q;
  assign invalid_op = inv_q;

  // Assertions
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(flags_nzcv) && $stable(invalid_op)));
  assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flags_nzcv == 4'b0110 || flags_nzcv == 4'b1000 ||
                   flags_nzcv == 4'b0010 || flags_nzcv == 4'b0011));
  assert_unordered_pure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flags_nzcv[0]) |-> (flags_nzcv == 4'b0011));
  assert_invalid_needs_nan_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && invalid_op) |-> (flags_nzcv == 4'b0011));
  assert_zero_vs_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && zero_rhs && (lhs_word[MAG_W-1:0] == '0))
      |=> (flags_nzcv == 4'b0110 && !invalid_op));
endmodule

// File: tb/fcmp_flags_tb.sv
module fcmp_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] lhs_word, rhs_word;
  logic        trap_qnan, zero_rhs;
  logic        res_valid;
  logic [3:0]  flags_nzcv;
  logic        invalid_op;

  int n_checks = 0;
  int n_fail   = 0;
  logic [3:0] last_f = 4'b0000;
  logic       last_i = 1'b0;

  typedef struct {
    logic [3:0] f;
    logic       inv;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_flags u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .lhs_word(lhs_word), .rhs_word(rhs_word),
    .trap_qnan(trap_qnan), .zero_rhs(zero_rhs),
    .res_valid(res_valid), .flags_nzcv(flags_nzcv), .invalid_op(invalid_op)
  );

  // Reference model: ordering by signed magnitude key
  function automatic logic [4:0] model(logic [31:0] l, logic [31:0] r,
                                       logic sq, logic z);
    logic [31:0] rr;
    logic nl, nr, inv;
    longint kl, kr;
    rr = z ? 32'h0 : r;
    nl = (l[30:23] == 8'hFF) && (l[22:0] != 0);
    nr = (rr[30:23] == 8'hFF) && (rr[22:0] != 0);
    if (nl || nr) begin
      inv = (nl && (!l[22] || sq)) || (nr && (!rr[22] || sq));
      return {4'b0011, inv};
    end
    kl = longint'(l[30:0]);  if (l[31])  kl = -kl;
    kr = longint'(rr[30:0]); if (rr[31]) kr = -kr;
    if (kl == kr) return {4'b0110, 1'b0};
    if (kl < kr)  return {4'b1000, 1'b0};
    return {4'b0010, 1'b0};
  endfunction

  task automatic check(string tag, logic [3:0] gf, logic gi,
                       logic [3:0] ef, logic ei);
    n_checks++;
    if (gf !== ef || gi !== ei) begin
      n_fail++;
      $display("FAIL %s: got flags=%b inv=%b expected flags=%b inv=%b",
               tag, gf, gi, ef, ei);
    end
  endtask

  task automatic send(logic [31:0] l, logic [31:0] r, logic sq, logic z,
                      string tag);
    exp_t e;
    logic [4:0] m;
    @(posedge clk); #1;
    req_valid = 1'b1; lhs_word = l; rhs_word = r; trap_qnan = sq; zero_rhs = z;
    m = model(l, r, sq, z);
    e.f = m[4:1]; e.inv = m[0]; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
    lhs_word = 32'h7FC0_0000; rhs_word = 32'h7F80_0001; zero_rhs = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2: result without request, got flags=%b expected none",
                 flags_nzcv);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, flags_nzcv, invalid_op, e.f, e.inv);
        last_f = flags_nzcv; last_i = invalid_op;
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] s;
    logic [31:0] a, b;
    rst_n = 1'b0; req_valid = 1'b0; lhs_word = '0; rhs_word = '0;
    trap_qnan = 1'b0; zero_rhs = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", flags_nzcv, invalid_op, 4'b0000, 1'b0);
    check("R1 valid in reset", {3'b000, res_valid}, 1'b0, 4'b0000, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", {res_valid, flags_nzcv[2:0]}, invalid_op, 4'b0000, 1'b0);

    // R3 equality
    send(32'h3F80_0000, 32'h3F80_0000, 0, 0, "R3 same word");
    send(32'h0000_0000, 32'h8000_0000, 0, 0, "R3 +0 vs -0");
    send(32'h8000_0000, 32'h0000_0000, 1, 0, "R3 -0 vs +0");
    // R4 differing signs
    send(32'hBF80_0000, 32'h3F80_0000, 0, 0, "R4 neg<pos");
    send(32'h0000_0001, 32'h8000_0001, 0, 0, "R4 pos>neg");
    send(32'hFF80_0000, 32'h0000_0000, 0, 0, "R4 -inf<+0");
    // R5 both positive
    send(32'h3F80_0000, 32'h4000_0000, 0, 0, "R5 1<2");
    send(32'h7F80_0000, 32'h7F7F_FFFF, 0, 0, "R5 inf>max");
    send(32'h0000_0001, 32'h0000_0002, 0, 0, "R5 subnormals");
    // R6 both negative
    send(32'hC000_0000, 32'hBF80_0000, 0, 0, "R6 -2<-1");
    send(32'hBF80_0000, 32'hFF80_0000, 0, 0, "R6 -1>-inf");
    idle();
    // R2 hold while idle
    repeat (3) @(negedge clk);
    check("R2 hold", flags_nzcv, invalid_op, last_f, last_i);
    check("R2 valid low", {3'b000, res_valid}, 1'b0, 4'b0000, 1'b0);
    // R7, R8, R9 NaNs
    send(32'h7FC0_0000, 32'h3F80_0000, 0, 0, "R7 qnan lhs quiet mode");
    send(32'h3F80_0000, 32'hFFC0_0001, 0, 0, "R7 qnan rhs");
    send(32'h7F80_0001, 32'h3F80_0000, 0, 0, "R8 snan lhs quiet mode");
    send(32'h3F80_0000, 32'h7FA0_0000, 1, 0, "R8 snan rhs signal mode");
    send(32'h7FC0_0000, 32'h0000_0000, 1, 0, "R9 qnan signal mode");
    send(32'h7FC0_0000, 32'h7FC0_0000, 0, 0, "R9 two qnan quiet mode");
    // R11 no invalid on ordinary compare in signalling mode
    send(32'h7F80_0000, 32'hFF80_0000, 1, 0, "R11 inf vs -inf signal");
    // R10 compare with zero, rhs ignored
    send(32'h8000_0000, 32'h7F80_0001, 1, 1, "R10 -0 vs zero, rhs snan ignored");
    send(32'hBF80_0000, 32'h7FC0_0000, 0, 1, "R10 neg vs zero");
    send(32'h0000_0001, 32'hFF80_0000, 0, 1, "R10 tiny vs zero");
    send(32'h7FC0_0000, 32'h0000_0000, 0, 1, "R10 qnan vs zero");
    idle();
    repeat (2) @(negedge clk);

    // Mixed random stream
    s = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      a = s;
      case (s[3:1])
        3'd0: a = {s[31], 31'h0};
        3'd1: a = {s[31], 8'hFF, 23'h0};
        3'd2: a = {s[31], 8'hFF, s[22], s[21:0] | 22'h1};
        default: ;
      endcase
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      b = s;
      if (s[5:4] == 2'b00) b = {s[31], a[30:0]};
      if (s[8:6] == 3'b000) b = {s[31], 8'hFF, 23'h0};
      send(a, b, s[9], s[12:10] == 3'b000, "R5,R6,R7 stream");
      if (s[15:13] == 3'b000) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R2: %0d results missing, expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule